// File: doc/BRIEF.md
# GPIO port edge/level interrupt controller

This block is one general-purpose I/O port of eight lines with per-line interrupt detection. Software reaches it over a byte-wide register bus with single-cycle writes and combinational reads. One register sets the output values and another sets the output enables. Reading the data address returns the synchronized level seen at the pads, so software sees the actual pin state whichever way a line is driven.

Each line has an interrupt enable, a detection-kind bit (level or edge), a polarity bit and a debounce enable. Pad inputs first pass through a two-flop synchronizer. When debounce is on, a line's new value is accepted only after it has held for four consecutive clocks. An edge of the selected polarity sets a sticky latch, and the latch sets even while the line is disabled. Software clears the latch by writing one to that line's bit of the end-of-interrupt address. In level mode nothing is latched: the request follows the filtered level. The block drives a combined request for ports that share one interrupt, and also one request per line for ports that give each line its own interrupt.

The addresses are: data at 0x00, direction at 0x10, detection kind at 0x90, polarity at 0x94, end-of-interrupt at 0x98, enable at 0x9C, status at 0xA0 and debounce at 0xA8.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0. `pad_out`, `pad_oe`, `irq_line` and `irq_any` are 0, so every line is an input with its interrupt disabled.
- R2: A write to 0x00 sets `pad_out`. A write to 0x10 sets `pad_oe`, where bit value 1 makes the line an output. The registers at 0x10, 0x90, 0x94, 0x9C and 0xA8 read back what was written. A read of 0x00 returns the pad levels, which appear two clock edges after the pads change.
- R3: With detection-kind bit 1 (edge) and polarity bit 1, a rising pad edge with debounce off sets the line's status bit on the third clock edge after the pad change.
- R4: With detection-kind bit 1 and polarity bit 0, a falling edge sets the latch and a rising edge does not.
- R5: An edge on a line whose enable bit is 0 is still latched. Status and request stay 0 until the enable bit is set, and then they become 1.
- R6: Writing 1 to a bit at 0x98 clears that line's edge latch. Writing 0 leaves it unchanged.
- R7: With detection-kind bit 0 (level), the status bit is 1 exactly when the filtered level equals the polarity bit and the line is enabled. Nothing is latched in this mode, and a write to 0x98 has no effect.
- R8: With debounce on, a new level counts only after it has held for 4 consecutive clocks. That gives 6 clock edges from the pad change to the filtered change, so the edge status sets on the 7th edge. A pulse lasting 3 clocks is rejected.
- R9: When an edge and an end-of-interrupt write to the same line fall in the same cycle, the latch ends at 1.
- R10: `irq_line[i]` equals status bit i, and `irq_any` is the OR of all status bits. Status reads at 0xA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Output data to the pads |
| pad_oe | output | 8 | Output enables (1 = drive) |
| irq_any | output | 1 | Combined interrupt request |
| irq_line | output | 8 | Per-line interrupt requests |

## Verification
The assertions assume that the pads are only ever observed through the synchronizer. They also assume a write is a single-cycle strobe with a stable address, so that a write's effect on the latch, the counter or a register lands on the edge that samples it. The bench changes pads and bus signals only at falling clock edges and holds the pads low through reset. It pulses the write strobe for exactly one cycle, which keeps the synchronizer and debounce timing deterministic and countable to the edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  parameter int ADDR_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_DATA = 8'h00;
  localparam addr_t A_DIR  = 8'h10;
  localparam addr_t A_KIND = 8'h90;
  localparam addr_t A_POL  = 8'h94;
  localparam addr_t A_EOI  = 8'h98;
  localparam addr_t A_IEN  = 8'h9C;
  localparam addr_t A_STAT = 8'hA0;
  localparam addr_t A_DEB  = 8'hA8;
endpackage

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
  parameter int LINES       = 8,
  parameter int DEB_SAMPLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pad_i,
  input  logic [LINES-1:0] deb_en,
  output logic [LINES-1:0] sync_o,
  output logic [LINES-1:0] filt_o
);
  localparam int CW = (DEB_SAMPLES > 2) ? $clog2(DEB_SAMPLES) : 1;

  logic [LINES-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pad_i;
      s2_q <= s1_q;
    end
  end

  assign sync_o = s2_q;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [CW-1:0] cnt_q, cnt_d;
    logic          held_q, held_d;

    always_comb begin
      cnt_d  = cnt_q;
      held_d = held_q;
      if (!deb_en[i]) begin
        cnt_d  = '0;
        held_d = s2_q[i];
      end else if (s2_q[i] == held_q) begin
        cnt_d = '0;
      end else if (cnt_q == CW'(DEB_SAMPLES - 1)) begin
        cnt_d  = '0;
        held_d = s2_q[i];
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        held_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_d;
        held_q <= held_d;
      end
    end

    assign filt_o[i] = deb_en[i] ? held_q : s2_q[i];

    AST_DEB_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(deb_en[i]) && (held_q != $past(held_q))) |->
        ($past(cnt_q) == CW'(DEB_SAMPLES - 1))); // R8
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] filt,
  input  logic [LINES-1:0] kind_edge,
  input  logic [LINES-1:0] pol_high,
  input  logic [LINES-1:0] ien,
  input  logic [LINES-1:0] eoi_pulse,
  output logic [LINES-1:0] status
);
  logic [LINES-1:0] prev_q, latch_q, latch_d;
  logic [LINES-1:0] rise, fall, edge_hit, clr, lvl_hit;

  always_comb begin
    rise     = filt & ~prev_q;
    fall     = ~filt & prev_q;
    edge_hit = kind_edge & ((pol_high & rise) | (~pol_high & fall));
    clr      = kind_edge & eoi_pulse;
    latch_d  = (latch_q & ~clr) | edge_hit;
    lvl_hit  = ~kind_edge & ~(filt ^ pol_high);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= filt;
      latch_q <= latch_d;
    end
  end

  assign status = ien & ((kind_edge & latch_q) | lvl_hit);

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit[i] |=> latch_q[i]); // R9
    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !edge_hit[i]) |=> !latch_q[i]); // R6
    AST_LEVEL_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !kind_edge[i] |=> !$rose(latch_q[i])); // R7
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_irq_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  addr_t            bus_addr,
  input  logic [LINES-1:0] bus_wdata,
  output logic [LINES-1:0] bus_rdata,
  input  logic [LINES-1:0] pin_lvl,
  input  logic [LINES-1:0] status,
  output logic [LINES-1:0] data_q,
  output logic [LINES-1:0] dir_q,
  output logic [LINES-1:0] kind_q,
  output logic [LINES-1:0] pol_q,
  output logic [LINES-1:0] ien_q,
  output logic [LINES-1:0] deb_q,
  output logic [LINES-1:0] eoi_pulse
);
  logic [LINES-1:0] data_d, dir_d, kind_d, pol_d, ien_d, deb_d;

  always_comb begin
    data_d = data_q;
    dir_d  = dir_q;
    kind_d = kind_q;
    pol_d  = pol_q;
    ien_d  = ien_q;
    deb_d  = deb_q;
    case (bus_addr)
      A_DATA:  data_d = bus_wdata;
      A_DIR:   dir_d  = bus_wdata;
      A_KIND:  kind_d = bus_wdata;
      A_POL:   pol_d  = bus_wdata;
      A_IEN:   ien_d  = bus_wdata;
      A_DEB:   deb_d  = bus_wdata;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      kind_q <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
      deb_q  <= '0;
    end else if (bus_we) begin
      data_q <= data_d;
      dir_q  <= dir_d;
      kind_q <= kind_d;
      pol_q  <= pol_d;
      ien_q  <= ien_d;
      deb_q  <= deb_d;
    end
  end

  assign eoi_pulse = (bus_we && bus_addr == A_EOI) ? bus_wdata : '0;

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = pin_lvl;
      A_DIR:   bus_rdata = dir_q;
      A_KIND:  bus_rdata = kind_q;
      A_POL:   bus_rdata = pol_q;
      A_IEN:   bus_rdata = ien_q;
      A_DEB:   bus_rdata = deb_q;
      A_STAT:  bus_rdata = status;
      default: bus_rdata = '0;
    endcase
  end

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_DIR) |=> $stable(dir_q)); // R2
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int LINES       = 8,
  parameter int DEB_SAMPLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  addr_t            bus_addr,
  input  logic [LINES-1:0] bus_wdata,
  output logic [LINES-1:0] bus_rdata,
  input  logic [LINES-1:0] pad_in,
  output logic [LINES-1:0] pad_out,
  output logic [LINES-1:0] pad_oe,
  output logic             irq_any,
  output logic [LINES-1:0] irq_line
);
  logic [1:0]       rsync_q;
  logic             rst_core_n;
  logic [LINES-1:0] sync_lvl, filt, status, eoi_pulse;
  logic [LINES-1:0] kind_q, pol_q, ien_q, deb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  gpio_port_regs #(.LINES(LINES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_lvl   (sync_lvl),
    .status    (status),
    .data_q    (pad_out),
    .dir_q     (pad_oe),
    .kind_q    (kind_q),
    .pol_q     (pol_q),
    .ien_q     (ien_q),
    .deb_q     (deb_q),
    .eoi_pulse (eoi_pulse)
  );

  gpio_in_filter #(.LINES(LINES), .DEB_SAMPLES(DEB_SAMPLES)) u_filt (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .pad_i  (pad_in),
    .deb_en (deb_q),
    .sync_o (sync_lvl),
    .filt_o (filt)
  );

  gpio_irq_detect #(.LINES(LINES)) u_det (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .filt      (filt),
    .kind_edge (kind_q),
    .pol_high  (pol_q),
    .ien       (ien_q),
    .eoi_pulse (eoi_pulse),
    .status    (status)
  );

  assign irq_line = status;
  assign irq_any  = |status;
endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] bus_rdata, pad_out, pad_oe, irq_line;
  logic       irq_any;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_any(irq_any), .irq_line(irq_line)
  );

  // {pad, polarity, enable, expected status}, level mode
  localparam logic [31:0] LVL_VEC [6] = '{
    32'hF0FFFFF0, 32'hF000FF0F, 32'hA50FFF55,
    32'hA50F3C14, 32'h00008181, 32'hFF00FF00
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [7:0] v;
    tick(3);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 irq", {7'd0, irq_any} | irq_line, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    tick(4);
    rd(8'h10, v); chk("R1 dir", v, 8'h00);
    rd(8'h90, v); chk("R1 kind", v, 8'h00);
    rd(8'h9C, v); chk("R1 ien", v, 8'h00);
    rd(8'hA0, v); chk("R1 status", v, 8'h00);

    // R2 data, direction, readback, pin level
    wr(8'h00, 8'h5A); chk("R2 pad_out", pad_out, 8'h5A);
    wr(8'h10, 8'h0F); chk("R2 pad_oe", pad_oe, 8'h0F);
    rd(8'h10, v); chk("R2 dir read", v, 8'h0F);
    wr(8'hA8, 8'h00); wr(8'h94, 8'hC3);
    rd(8'h94, v); chk("R2 pol read", v, 8'hC3);
    pad_in = 8'h3C;
    tick(1); rd(8'h00, v); chk("R2 pin early", v, 8'h00);
    tick(1); rd(8'h00, v); chk("R2 pin level", v, 8'h3C);

    // R7 R10 level mode vector table
    for (int k = 0; k < 6; k++) begin
      wr(8'h94, LVL_VEC[k][23:16]);
      wr(8'h9C, LVL_VEC[k][15:8]);
      pad_in = LVL_VEC[k][31:24];
      tick(3);
      rd(8'hA0, v); chk("R7 level status", v, LVL_VEC[k][7:0]);
      chk("R10 irq_line", irq_line, LVL_VEC[k][7:0]);
      chk("R10 irq_any", {7'd0, irq_any}, {7'd0, |LVL_VEC[k][7:0]});
    end

    // edge mode: line0 rising, others falling
    pad_in = 8'h00; tick(3);
    wr(8'h94, 8'h01); wr(8'h90, 8'hFF); wr(8'h9C, 8'hFF); wr(8'h98, 8'hFF);
    pad_in = 8'h01;
    tick(2); chk("R3 not yet", irq_line, 8'h00);
    tick(1); chk("R3 rising latched", irq_line, 8'h01);
    pad_in = 8'h03; tick(3); chk("R4 rising ignored", irq_line, 8'h01);
    pad_in = 8'h00; tick(3); chk("R4 falling latched", irq_line, 8'h03);
    wr(8'h98, 8'h00); chk("R6 eoi zero", irq_line, 8'h03);
    wr(8'h98, 8'h01); chk("R6 eoi line0", irq_line, 8'h02);
    wr(8'h98, 8'h02); chk("R6 eoi line1", irq_line, 8'h00);
    chk("R10 any low", {7'd0, irq_any}, 8'h00);

    // R5 disabled line still latches
    wr(8'h9C, 8'hFE);
    pad_in = 8'h01; tick(3);
    chk("R5 masked", irq_line, 8'h00);
    rd(8'hA0, v); chk("R5 masked status", v, 8'h00);
    wr(8'h9C, 8'hFF); chk("R5 unmasked", irq_line, 8'h01);
    wr(8'h98, 8'h01); chk("R6 clear", irq_line, 8'h00);

    // R9 edge and eoi in the same cycle
    pad_in = 8'h00; tick(3);
    pad_in = 8'h01; tick(2);
    wr(8'h98, 8'h01);
    chk("R9 set wins", irq_line, 8'h01);
    wr(8'h98, 8'h01); chk("R9 later clear", irq_line, 8'h00);

    // R7 eoi ignored in level mode
    wr(8'h90, 8'h00); wr(8'h94, 8'hFF);
    tick(1); chk("R7 level high", irq_line, 8'h01);
    wr(8'h98, 8'hFF); chk("R7 eoi ignored", irq_line, 8'h01);
    pad_in = 8'h00; tick(3); chk("R7 no latch", irq_line, 8'h00);

    // R8 debounce on line0, rising edge
    wr(8'h90, 8'hFF); wr(8'hA8, 8'h01); tick(4); wr(8'h98, 8'hFF);
    pad_in = 8'h01; tick(3); pad_in = 8'h00; tick(10);
    chk("R8 short pulse rejected", irq_line, 8'h00);
    pad_in = 8'h01;
    tick(6); chk("R8 not yet", irq_line, 8'h00);
    tick(1); chk("R8 accepted", irq_line, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule